// File: doc/BRIEF.md
# Data Watchpoint Comparator Bank

The block holds a parameterised set of data-address watchpoint units for a processor debug block. Software programs each unit through a plain register write port: one control word and one address value word per unit. The bank watches the core's memory-access interface every cycle and, when an enabled unit matches a valid access, raises a hit one cycle later together with the index of the lowest-numbered matching unit and the address of the access.

A unit matches in one of two ways. With a zero mask field it compares the doubleword address and then checks the bytes the access touches against an 8-bit byte-select lane mask. With a mask field of three or more it ignores that many low address bits and covers a naturally aligned power-of-two region. Every unit also filters by access direction (load or store) and by privilege level (user or kernel).

The access interface is an observation port: it carries a valid strobe but no ready, because the bank never stalls the core and accepts one access per cycle. The hit outputs are a one-cycle pulse with no back-pressure; the consumer must take them in the cycle they appear.

Top module: `dwb_bank`

## Requirements
- R1: After reset hit_valid is 0 and every unit is disabled, so no access produces a hit until a unit is programmed.
- R2: A write with cfg_we=1 goes to unit cfg_unit; cfg_sel=0 writes the control word, cfg_sel=1 writes the value word. Control bit 0 is the enable and a unit with enable 0 never matches. The low three value bits are ignored, so the base is doubleword aligned.
- R3: With mask field (control bits 28:24) equal to 0, a unit matches only when address bits above bit 2 equal the base and at least one byte the access touches has its byte-select bit (control bits 12:5, bit 5+k for byte k) set.
- R4: acc_size codes 0,1,2,3 mean 1,2,4,8 bytes; an access touches bytes addr[2:0] through addr[2:0]+N-1 of its doubleword, and bytes past byte 7 are dropped (a crossing access compares only its first doubleword).
- R5: Load/store control (control bits 4:3): 01 matches loads only, 10 stores only, 11 both, 00 nothing; acc_store=1 marks a store.
- R6: Privilege control (control bits 2:1): 01 matches kernel accesses only, 10 user only, 11 both, 00 nothing; acc_priv=1 marks kernel level.
- R7: With a mask field value M of 3 or more, address bits below M are ignored in the compare (base bits included), and the unit matches only if the byte-select is all ones.
- R8: Mask field values 1 and 2 are reserved and never match.
- R9: When several units match, hit_unit is the lowest-numbered one; hit_addr is the address of the access that hit.
- R10: hit_valid rises in the cycle after the accepted access and only for a cycle in which acc_valid was 1.
- R11: Control bits 19:16 and bit 20 have no effect on matching.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | 0 = control word, 1 = value word |
| cfg_unit | input | IDX_W | Unit index of the write |
| cfg_wdata | input | WD_W | Write data |
| acc_valid | input | 1 | Memory access present this cycle |
| acc_addr | input | ADDR_W | Access virtual address |
| acc_size | input | 2 | Log2 of access size in bytes |
| acc_store | input | 1 | 1 = store, 0 = load |
| acc_priv | input | 1 | 1 = kernel level, 0 = user level |
| hit_valid | output | 1 | A watchpoint hit for the previous cycle's access |
| hit_unit | output | IDX_W | Lowest matching unit |
| hit_addr | output | ADDR_W | Address of the access that hit |

## Verification
The hardest situations to reach are the ones where several units match the same access at once and where an access runs past the end of its doubleword, since a single programmed unit never exposes the priority order or the lane clipping. The stimulus programs overlapping units in a chosen pattern and then disables the winner to see the next one take over, and it places eight-byte accesses at byte offset 7 against byte-select masks that light only the first or only a wrapped-around lane. Masked regions are tested with a base value carrying bits below the mask, so that ignoring base bits is visible at the ports.

// File: rtl/dwb_pkg.sv
package dwb_pkg;
  // Field positions inside the control word
  localparam int C_EN    = 0;
  localparam int C_PAC_L = 1;
  localparam int C_LSC_L = 3;
  localparam int C_BAS_L = 5;
  localparam int C_MSK_L = 24;
  localparam int LANES   = 8;
  localparam int MSK_W   = 5;

  typedef struct packed {
    logic             en;
    logic [1:0]       pac;   // bit0 kernel, bit1 user
    logic [1:0]       lsc;   // bit0 load, bit1 store
    logic [LANES-1:0] bas;
    logic [MSK_W-1:0] amask;
  } wctl_t;
endpackage

// File: rtl/dwb_lanes.sv
module dwb_lanes
  import dwb_pkg::*;
(
  input  logic [2:0]       addr_lo,
  input  logic [1:0]       size,
  output logic [LANES-1:0] lanes
);
  always_comb begin
    int first;
    int last;
    first = int'(addr_lo);
    last  = first + (1 << size) - 1;
    for (int i = 0; i < LANES; i++) begin
      lanes[i] = (i >= first) && (i <= last);
    end
  end

  always_comb begin
    p_first_lane_r4: assert (lanes[addr_lo] == 1'b1);
  end
endmodule

// File: rtl/dwb_unit.sv
module dwb_unit
  import dwb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int WD_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctl,
  input  logic              wr_val,
  input  logic [WD_W-1:0]   wdata,
  input  logic [ADDR_W-1:3] acc_hi,
  input  logic [LANES-1:0]  acc_lanes,
  input  logic              acc_store,
  input  logic              acc_priv,
  output logic              match
);
  wctl_t             ctl;
  logic [ADDR_W-1:3] base_hi;
  logic [ADDR_W-1:3] keep_hi;
  logic              addr_eq, dir_ok, priv_ok, lane_ok, rgn_ok, rsvd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl     <= '0;
      base_hi <= '0;
    end else begin
      if (wr_ctl) begin
        ctl.en    <= wdata[C_EN];
        ctl.pac   <= wdata[C_PAC_L +: 2];
        ctl.lsc   <= wdata[C_LSC_L +: 2];
        ctl.bas   <= wdata[C_BAS_L +: LANES];
        ctl.amask <= wdata[C_MSK_L +: MSK_W];
      end
      if (wr_val) base_hi <= wdata[ADDR_W-1:3];
    end
  end

  always_comb begin
    for (int i = 3; i < ADDR_W; i++) keep_hi[i] = (i >= int'(ctl.amask));
  end

  assign addr_eq = (((acc_hi ^ base_hi) & keep_hi) == '0);
  assign dir_ok  = acc_store ? ctl.lsc[1] : ctl.lsc[0];
  assign priv_ok = acc_priv  ? ctl.pac[0] : ctl.pac[1];
  assign rsvd    = (ctl.amask == MSK_W'(1)) || (ctl.amask == MSK_W'(2));
  assign lane_ok = (ctl.amask == '0) && ((acc_lanes & ctl.bas) != '0);
  assign rgn_ok  = (ctl.amask != '0) && !rsvd && (ctl.bas == '1);
  assign match   = ctl.en && dir_ok && priv_ok && addr_eq && (lane_ok || rgn_ok);

  p_write_disable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctl && !wdata[C_EN]) |=> !match);
  p_reserved_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctl && (wdata[C_MSK_L +: MSK_W] == MSK_W'(1) || wdata[C_MSK_L +: MSK_W] == MSK_W'(2)))
      |=> !match);
endmodule

// File: rtl/dwb_prio.sv
module dwb_prio #(
  parameter int N     = 4,
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     req,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  logic [N-1:0] gnt;

  assign gnt = req & (~req + N'(1));
  assign any = |req;

  always_comb begin
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (gnt[i]) idx = IDX_W'(i);
    end
  end

  p_one_winner_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt) && ((gnt & ~req) == '0) && (any == (gnt != '0)));
endmodule

// File: rtl/dwb_bank.sv
module dwb_bank
  import dwb_pkg::*;
#(
  parameter int N_UNITS = 4,
  parameter int ADDR_W  = 32,
  parameter int IDX_W   = (N_UNITS > 1) ? $clog2(N_UNITS) : 1,
  parameter int WD_W    = (ADDR_W > 32) ? ADDR_W : 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [IDX_W-1:0]  cfg_unit,
  input  logic [WD_W-1:0]   cfg_wdata,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [1:0]        acc_size,
  input  logic              acc_store,
  input  logic              acc_priv,
  output logic              hit_valid,
  output logic [IDX_W-1:0]  hit_unit,
  output logic [ADDR_W-1:0] hit_addr
);
  logic [LANES-1:0]   lanes;
  logic [N_UNITS-1:0] match;
  logic               any;
  logic [IDX_W-1:0]   win;

  dwb_lanes u_lanes (
    .addr_lo (acc_addr[2:0]),
    .size    (acc_size),
    .lanes   (lanes)
  );

  for (genvar g = 0; g < N_UNITS; g++) begin : g_unit
    logic sel_me;
    assign sel_me = cfg_we && (cfg_unit == IDX_W'(g));
    dwb_unit #(.ADDR_W(ADDR_W), .WD_W(WD_W)) u_unit (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_ctl    (sel_me && !cfg_sel),
      .wr_val    (sel_me && cfg_sel),
      .wdata     (cfg_wdata),
      .acc_hi    (acc_addr[ADDR_W-1:3]),
      .acc_lanes (lanes),
      .acc_store (acc_store),
      .acc_priv  (acc_priv),
      .match     (match[g])
    );
  end

  dwb_prio #(.N(N_UNITS), .IDX_W(IDX_W)) u_prio (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (match),
    .any   (any),
    .idx   (win)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hit_valid <= 1'b0;
      hit_unit  <= '0;
      hit_addr  <= '0;
    end else begin
      hit_valid <= acc_valid && any;
      if (acc_valid) begin
        hit_unit <= win;
        hit_addr <= acc_addr;
      end
    end
  end

  p_hit_after_access_r10: assert property (@(posedge clk) disable iff (!rst_n)
    hit_valid |-> $past(acc_valid));
  p_idle_no_hit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> !hit_valid);
  p_hit_addr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    hit_valid |-> (hit_addr == $past(acc_addr)));
endmodule

// File: tb/dwb_bank_test.sv
module dwb_bank_test;
  localparam int ADDR_W = 32;
  localparam int IDX_W  = 2;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cfg_we = 1'b0, cfg_sel = 1'b0;
  logic [IDX_W-1:0]  cfg_unit = '0;
  logic [31:0]       cfg_wdata = '0;
  logic              acc_valid = 1'b0;
  logic [ADDR_W-1:0] acc_addr = '0;
  logic [1:0]        acc_size = '0;
  logic              acc_store = 1'b0, acc_priv = 1'b0;
  logic              hit_valid;
  logic [IDX_W-1:0]  hit_unit;
  logic [ADDR_W-1:0] hit_addr;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  dwb_bank #(.N_UNITS(4), .ADDR_W(ADDR_W)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_unit(cfg_unit), .cfg_wdata(cfg_wdata), .acc_valid(acc_valid),
    .acc_addr(acc_addr), .acc_size(acc_size), .acc_store(acc_store),
    .acc_priv(acc_priv), .hit_valid(hit_valid), .hit_unit(hit_unit),
    .hit_addr(hit_addr)
  );

  function automatic logic [31:0] mk(int msk, int bas, int lsc, int pac, int en);
    return 32'((msk << 24) | (bas << 5) | (lsc << 3) | (pac << 1) | en);
  endfunction

  typedef struct packed {
    logic [31:0] ctl;
    logic [31:0] val;
    logic [31:0] addr;
    logic [1:0]  sz;
    logic        st;
    logic        pr;
    logic        ex;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 25;
  localparam vec_t TAB [NV] = '{
    '{mk(0,8'h01,3,3,1), 32'h1000, 32'h1000, 2'd0, 1'b0, 1'b0, 1'b1, 8'd3},  // R3 lane 0
    '{mk(0,8'h01,3,3,1), 32'h1000, 32'h1001, 2'd0, 1'b0, 1'b0, 1'b0, 8'd3},  // R3 other lane
    '{mk(0,8'hFF,3,3,1), 32'h1000, 32'h1008, 2'd0, 1'b0, 1'b0, 1'b0, 8'd3},  // R3 next dword
    '{mk(0,8'h10,3,3,1), 32'h1000, 32'h1002, 2'd2, 1'b0, 1'b0, 1'b1, 8'd4},  // R4 bytes 2..5
    '{mk(0,8'h40,3,3,1), 32'h1000, 32'h1002, 2'd2, 1'b0, 1'b0, 1'b0, 8'd4},  // R4 lane 6 untouched
    '{mk(0,8'h01,3,3,1), 32'h1000, 32'h1007, 2'd3, 1'b0, 1'b0, 1'b0, 8'd4},  // R4 crossing, no wrap
    '{mk(0,8'h80,3,3,1), 32'h1000, 32'h1007, 2'd3, 1'b0, 1'b0, 1'b1, 8'd4},  // R4 crossing, lane 7
    '{mk(0,8'h08,3,3,1), 32'h1000, 32'h1002, 2'd1, 1'b0, 1'b0, 1'b1, 8'd4},  // R4 halfword 2..3
    '{mk(0,8'h01,1,3,1), 32'h1000, 32'h1000, 2'd0, 1'b0, 1'b0, 1'b1, 8'd5},  // R5 load-only load
    '{mk(0,8'h01,1,3,1), 32'h1000, 32'h1000, 2'd0, 1'b1, 1'b0, 1'b0, 8'd5},  // R5 load-only store
    '{mk(0,8'h01,2,3,1), 32'h1000, 32'h1000, 2'd0, 1'b1, 1'b0, 1'b1, 8'd5},  // R5 store-only store
    '{mk(0,8'h01,2,3,1), 32'h1000, 32'h1000, 2'd0, 1'b0, 1'b0, 1'b0, 8'd5},  // R5 store-only load
    '{mk(0,8'h01,0,3,1), 32'h1000, 32'h1000, 2'd0, 1'b1, 1'b0, 1'b0, 8'd5},  // R5 none
    '{mk(0,8'h01,3,1,1), 32'h1000, 32'h1000, 2'd0, 1'b0, 1'b1, 1'b1, 8'd6},  // R6 kernel-only kernel
    '{mk(0,8'h01,3,1,1), 32'h1000, 32'h1000, 2'd0, 1'b0, 1'b0, 1'b0, 8'd6},  // R6 kernel-only user
    '{mk(0,8'h01,3,2,1), 32'h1000, 32'h1000, 2'd0, 1'b0, 1'b0, 1'b1, 8'd6},  // R6 user-only user
    '{mk(0,8'h01,3,0,1), 32'h1000, 32'h1000, 2'd0, 1'b0, 1'b1, 1'b0, 8'd6},  // R6 none
    '{mk(4,8'hFF,3,3,1), 32'h1000, 32'h100F, 2'd0, 1'b0, 1'b0, 1'b1, 8'd7},  // R7 16B region top
    '{mk(4,8'hFF,3,3,1), 32'h1000, 32'h1010, 2'd0, 1'b0, 1'b0, 1'b0, 8'd7},  // R7 past region
    '{mk(4,8'h7F,3,3,1), 32'h1000, 32'h1000, 2'd0, 1'b0, 1'b0, 1'b0, 8'd7},  // R7 partial select
    '{mk(12,8'hFF,3,3,1),32'h1234, 32'h1ABC, 2'd2, 1'b1, 1'b1, 1'b1, 8'd7},  // R7 base low bits ignored
    '{mk(1,8'hFF,3,3,1), 32'h1000, 32'h1000, 2'd0, 1'b0, 1'b0, 1'b0, 8'd8},  // R8 mask 1
    '{mk(2,8'hFF,3,3,1), 32'h1000, 32'h1000, 2'd0, 1'b0, 1'b0, 1'b0, 8'd8},  // R8 mask 2
    '{mk(0,8'h01,3,3,1) | 32'h001F_0000, 32'h1000, 32'h1000, 2'd0, 1'b0, 1'b0, 1'b1, 8'd11}, // R11
    '{mk(0,8'hFF,3,3,0), 32'h1000, 32'h1000, 2'd0, 1'b0, 1'b0, 1'b0, 8'd2}   // R2 disabled
  };

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(int unit, bit sel, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_unit = IDX_W'(unit); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // One access cycle; outputs are sampled at the following falling edge
  task automatic acc(logic [31:0] a, logic [1:0] sz, bit st, bit pr);
    @(negedge clk);
    acc_valid = 1'b1; acc_addr = a; acc_size = sz; acc_store = st; acc_priv = pr;
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(hit_valid == 1'b0, "R1 reset hit_valid", 32'(hit_valid), 32'd0);
    rst_n = 1'b1;
    // R1: nothing programmed, a broad access must not hit
    acc(32'h0, 2'd3, 1'b0, 1'b1);
    chk(hit_valid == 1'b0, "R1 unprogrammed", 32'(hit_valid), 32'd0);

    // Table walk on unit 0, other units left disabled
    for (int i = 0; i < NV; i++) begin
      string tag;
      wr(0, 1'b0, TAB[i].ctl);
      wr(0, 1'b1, TAB[i].val);
      acc(TAB[i].addr, TAB[i].sz, TAB[i].st, TAB[i].pr);
      tag = $sformatf("R%0d vec%0d", TAB[i].req, i);
      chk(hit_valid == TAB[i].ex, tag, 32'(hit_valid), 32'(TAB[i].ex));
      if (TAB[i].ex) begin
        chk(hit_unit == '0, {tag, " unit"}, 32'(hit_unit), 32'd0);
        chk(hit_addr == TAB[i].addr, {tag, " addr"}, hit_addr, TAB[i].addr);
      end
    end

    // R2: value low bits ignored, base 0x2007 acts as 0x2000
    wr(0, 1'b0, mk(0, 8'h01, 3, 3, 1));
    wr(0, 1'b1, 32'h2007);
    acc(32'h2000, 2'd0, 1'b0, 1'b0);
    chk(hit_valid == 1'b1, "R2 value low bits", 32'(hit_valid), 32'd1);

    // R9: units 1 and 3 match, unit 2 misses, unit 0 disabled
    wr(0, 1'b0, mk(0, 8'hFF, 3, 3, 0));
    wr(1, 1'b0, mk(0, 8'hFF, 3, 3, 1)); wr(1, 1'b1, 32'h3000);
    wr(2, 1'b0, mk(0, 8'hFF, 3, 3, 1)); wr(2, 1'b1, 32'h4000);
    wr(3, 1'b0, mk(5, 8'hFF, 3, 3, 1)); wr(3, 1'b1, 32'h3010);
    acc(32'h3004, 2'd0, 1'b1, 1'b0);
    chk(hit_valid == 1'b1, "R9 multi hit", 32'(hit_valid), 32'd1);
    chk(hit_unit == 2'd1, "R9 lowest unit", 32'(hit_unit), 32'd1);
    chk(hit_addr == 32'h3004, "R9 hit addr", hit_addr, 32'h3004);
    wr(1, 1'b0, mk(0, 8'hFF, 3, 3, 0));
    acc(32'h3004, 2'd0, 1'b1, 1'b0);
    chk(hit_unit == 2'd3, "R9 next unit", 32'(hit_unit), 32'd3);
    acc(32'h4001, 2'd0, 1'b0, 1'b0);
    chk(hit_unit == 2'd2, "R9 unit 2", 32'(hit_unit), 32'd2);

    // R10: hit for one cycle only, none while acc_valid is low
    @(negedge clk);
    chk(hit_valid == 1'b0, "R10 pulse ends", 32'(hit_valid), 32'd0);
    acc_addr = 32'h4000; acc_size = 2'd0; acc_valid = 1'b0;
    @(negedge clk);
    chk(hit_valid == 1'b0, "R10 no strobe", 32'(hit_valid), 32'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule